// File: doc/BRIEF.md
# Programmable Four-Mode Delay Timer

This block turns a trigger level into a delayed, active-low output. The delay is N ticks, where N is an 8-bit binary-weighted word. A tick is either every clock or one pulse from an internal prescaler. The prescaler lets a 50 Hz line, a 60 Hz line or a 32.768 kHz crystal clock produce ticks one second apart. A 2-bit mode code sets how the trigger's rising and falling edges map onto the output:

- a non-retriggerable pulse;
- a delayed pull-in;
- a delayed drop-out;
- a delay on both edges.

A synchronous abort input stops any delay that is running and returns the output to its idle (high) level. The trigger and abort inputs may be asynchronous to the clock. Both pass through a synchronizer before an edge detector. Mode, delay word and time-base select are expected to stay stable while a delay runs.

Top module: `delay_timer`

## Requirements
- R1: While `rst_n` is low, and after its release until a trigger edge arrives, `dly_out_o` is high (inactive) and no delay runs.
- R2: `tick_sel_i` selects the tick: 00 every clock, 01 one per 50 clocks, 10 one per 60 clocks, 11 one per 32768 clocks. The divider restarts whenever a delay is armed, so a delay of N lasts exactly N times the divisor in clock cycles, counted from the edge on which an immediate response would land.
- R3: Mode 00 (single pulse): a trigger rise drives the output low at once and arms the delay, and the output goes high when the delay ends. Trigger falls are ignored. A rise that arrives while the delay runs is ignored.
- R4: Mode 01 (delayed pull-in): a rise arms the delay, and the output goes low only when the delay ends. A fall drives the output high at once and cancels any pending delay.
- R5: Mode 10 (delayed drop-out): a rise drives the output low at once and cancels any pending delay. A fall arms the delay, and the output goes high when the delay ends.
- R6: Mode 11 (both delayed): a rise arms a delay that ends with the output low, and a fall arms a delay that ends with the output high. The newer edge replaces any pending delay.
- R7: A delay word of 0 applies the delayed level on the same edge as an immediate response and never leaves a delay running. In mode 00 the low and high steps then merge, so the output stays high.
- R8: While the synchronized abort is high, the output is forced high, the delay and divider are cleared, and trigger edges have no effect. After release, the next trigger starts a full-length delay.
- R9: Trigger and abort pass through two synchronizer flops and an edge register. An immediate response appears on the third rising clock edge after the input changes. The output changes only in response to a trigger edge, a delay expiry or abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| trig_i | input | 1 | Trigger level, asynchronous to `clk` |
| abort_i | input | 1 | Abort level, asynchronous to `clk`, active high |
| mode_i | input | 2 | Mode code: 00 pulse, 01 delayed pull-in, 10 delayed drop-out, 11 both delayed |
| delay_i | input | DLY_W (8) | Delay length in ticks |
| tick_sel_i | input | 2 | Time base: 00 direct, 01 divide by 50, 10 divide by 60, 11 divide by 32768 |
| dly_out_o | output | 1 | Delayed output, active low |

## Verification
The assertions check, on every cycle, the per-edge effects that land one clock later:
- an abort releases the output and clears any running delay;
- a fall in the pull-in mode releases the output and cancels the delay;
- a rise in the drop-out mode pulls the output low and cancels the delay;
- either edge in the both-delayed mode arms the delay, and a zero word never arms it;
- the output stays low while a pulse runs, and every output change has a cause.

Only the bench scenarios can show the exact length of each delay, in ticks and in divided clocks, and the full three-edge latency of the synchronizer path. The same holds for ignored retriggers, cancellation of a pending delay by an opposite edge, and the full-length restart after an abort.

// File: rtl/dly_pkg.sv
package dly_pkg;

  typedef enum logic [1:0] {
    MODE_PULSE    = 2'b00,
    MODE_ON_DLY   = 2'b01,
    MODE_OFF_DLY  = 2'b10,
    MODE_BOTH_DLY = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    TB_DIRECT = 2'b00,
    TB_DIV_A  = 2'b01,
    TB_DIV_B  = 2'b10,
    TB_DIV_C  = 2'b11
  } tbase_e;

  // Action requested by one synchronized trigger edge.
  typedef struct packed {
    logic imm;      // apply imm_val to the output now
    logic imm_val;
    logic cancel;   // drop a pending delay
    logic start;    // arm the delay
    logic tgt;      // output level applied when the delay ends
  } act_t;

  function automatic act_t dly_decode(input mode_e mode, input logic rise,
                                      input logic fall, input logic busy);
    act_t a;
    a = '0;
    unique case (mode)
      MODE_PULSE: begin
        if (rise && !busy) begin
          a.imm = 1'b1; a.imm_val = 1'b0;
          a.start = 1'b1; a.tgt = 1'b1;
        end
      end
      MODE_ON_DLY: begin
        if (rise) begin
          a.start = 1'b1; a.tgt = 1'b0;
        end else if (fall) begin
          a.imm = 1'b1; a.imm_val = 1'b1; a.cancel = 1'b1;
        end
      end
      MODE_OFF_DLY: begin
        if (rise) begin
          a.imm = 1'b1; a.imm_val = 1'b0; a.cancel = 1'b1;
        end else if (fall) begin
          a.start = 1'b1; a.tgt = 1'b1;
        end
      end
      MODE_BOTH_DLY: begin
        if (rise) begin
          a.start = 1'b1; a.tgt = 1'b0;
        end else if (fall) begin
          a.start = 1'b1; a.tgt = 1'b1;
        end
      end
      default: a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/dly_sync.sv
module dly_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[g] <= '0;
        else        st_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[g] <= '0;
        else        st_q[g] <= st_q[g-1];
      end
    end
  end

  assign q = st_q[STAGES-1];

endmodule

// File: rtl/dly_edge.sv
module dly_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/dly_prescaler.sv
module dly_prescaler import dly_pkg::*; #(
  parameter int DIV_A = 50,
  parameter int DIV_B = 60,
  parameter int DIV_C = 32768,
  localparam int DIV_MAX = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                           : ((DIV_B > DIV_C) ? DIV_B : DIV_C),
  localparam int PC_W = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       clr,
  output logic       tick
);

  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic [PC_W-1:0] last;
  logic            direct;
  logic            pcnt_en;

  always_comb begin
    direct = 1'b0;
    unique case (tbase_e'(sel))
      TB_DIRECT: begin last = '0; direct = 1'b1; end
      TB_DIV_A:  last = PC_W'(DIV_A - 1);
      TB_DIV_B:  last = PC_W'(DIV_B - 1);
      TB_DIV_C:  last = PC_W'(DIV_C - 1);
      default:   begin last = '0; direct = 1'b1; end
    endcase
  end

  assign tick = direct | (pcnt_q == last);

  always_comb begin
    pcnt_en = 1'b1;
    if (clr || direct || (pcnt_q >= last)) pcnt_d = '0;
    else                                   pcnt_d = pcnt_q + 1'b1;
    if (direct && (pcnt_q == '0)) pcnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

endmodule

// File: rtl/dly_ctrl.sv
module dly_ctrl import dly_pkg::*; #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [DLY_W-1:0] delay,
  input  logic             rise,
  input  logic             fall,
  input  logic             tick,
  input  logic             abort,
  output logic             busy,
  output logic             pre_clr,
  output logic             out
);

  logic             busy_q, busy_d;
  logic [DLY_W-1:0] rem_q, rem_d;
  logic             tgt_q, tgt_d;
  logic             out_q, out_d;
  logic             start;
  logic             st_en;
  act_t             act;

  always_comb begin
    act    = dly_decode(mode_e'(mode), rise, fall, busy_q);
    busy_d = busy_q;
    rem_d  = rem_q;
    tgt_d  = tgt_q;
    out_d  = out_q;
    start  = 1'b0;

    // expiry of a running delay
    if (busy_q && tick) begin
      if (rem_q == DLY_W'(1)) begin
        busy_d = 1'b0;
        out_d  = tgt_q;
      end else begin
        rem_d = rem_q - 1'b1;
      end
    end

    // edge actions take precedence over a coincident expiry
    if (act.cancel) busy_d = 1'b0;
    if (act.imm)    out_d  = act.imm_val;
    if (act.start) begin
      if (delay == '0) begin
        busy_d = 1'b0;
        out_d  = act.tgt;
      end else begin
        busy_d = 1'b1;
        rem_d  = delay;
        tgt_d  = act.tgt;
        start  = 1'b1;
      end
    end

    if (abort) begin
      busy_d = 1'b0;
      rem_d  = '0;
      tgt_d  = 1'b1;
      out_d  = 1'b1;
      start  = 1'b0;
    end
  end

  assign st_en = abort | busy_q | act.imm | act.start | act.cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      tgt_q  <= 1'b1;
      out_q  <= 1'b1;
    end else if (st_en) begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
      tgt_q  <= tgt_d;
      out_q  <= out_d;
    end
  end

  assign busy    = busy_q;
  assign out     = out_q;
  assign pre_clr = start | abort;

endmodule

// File: rtl/delay_timer.sv
module delay_timer #(
  parameter int DLY_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 50,
  parameter int DIV_B       = 60,
  parameter int DIV_C       = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             abort_i,
  input  logic [1:0]       mode_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [1:0]       tick_sel_i,
  output logic             dly_out_o
);

  localparam int N_SYNC = 2;

  logic [N_SYNC-1:0] sync_q;
  logic              trig_s;
  logic              abort_s;
  logic              trig_rise;
  logic              trig_fall;
  logic              tick;
  logic              pre_clr;
  logic              busy;

  dly_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({abort_i, trig_i}),
    .q     (sync_q)
  );

  assign trig_s  = sync_q[0];
  assign abort_s = sync_q[1];

  dly_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (trig_s),
    .rise  (trig_rise),
    .fall  (trig_fall)
  );

  dly_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (tick_sel_i),
    .clr   (pre_clr),
    .tick  (tick)
  );

  dly_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_i),
    .delay   (delay_i),
    .rise    (trig_rise),
    .fall    (trig_fall),
    .tick    (tick),
    .abort   (abort_s),
    .busy    (busy),
    .pre_clr (pre_clr),
    .out     (dly_out_o)
  );

endmodule

// File: rtl/dly_timer_chk.sv
module dly_timer_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [DLY_W-1:0] delay,
  input logic [1:0]       tick_sel,
  input logic             out,
  input logic             busy,
  input logic             trig_rise,
  input logic             trig_fall,
  input logic             abort_s,
  input logic             tick
);

  // R2: direct time base ticks on every clock
  a_r2_direct_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sel == 2'b00) |-> tick);

  // R3: output held low for the whole pulse
  a_r3_pulse_low_while_run: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && busy) |-> !out);

  // R4: fall in pull-in mode releases at once and cancels
  a_r4_on_fall_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && trig_fall && !abort_s) |=> (out && !busy));

  // R5: rise in drop-out mode pulls low at once and cancels
  a_r5_off_rise_grab: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && trig_rise && !abort_s) |=> (!out && !busy));

  // R6: either edge arms the delay in both-delayed mode
  a_r6_both_edge_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && (trig_rise || trig_fall) && !abort_s && delay != '0) |=> busy);

  // R7: a zero word never leaves a delay running
  a_r7_zero_never_arms: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(delay) != '0));

  // R8: abort releases the output and clears the delay
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_s |=> (out && !busy));

  // R9: every output change has a cause in the cycle before
  a_r9_out_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out) |-> $past(trig_rise || trig_fall || tick || abort_s));

endmodule

bind delay_timer dly_timer_chk #(.DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode_i),
  .delay     (delay_i),
  .tick_sel  (tick_sel_i),
  .out       (dly_out_o),
  .busy      (busy),
  .trig_rise (trig_rise),
  .trig_fall (trig_fall),
  .abort_s   (abort_s),
  .tick      (tick)
);

// File: tb/delay_timer_tb.sv
module delay_timer_tb;

  logic       clk;
  logic       rst_n;
  logic       trig;
  logic       abort;
  logic [1:0] mode;
  logic [7:0] dly;
  logic [1:0] tsel;
  logic       dout;

  int  cyc;
  int  n_chk;
  int  n_fail;
  bit  done;

  typedef struct {
    int    c;
    bit    v;
    string r;
  } exp_t;

  exp_t sb[$];

  delay_timer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig),
    .abort_i    (abort),
    .mode_i     (mode),
    .delay_i    (dly),
    .tick_sel_i (tsel),
    .dly_out_o  (dout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit act, input bit exp_v, input string r, input int c);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: dly_out_o=%0b expected %0b", r, c, act, exp_v);
    end
  endtask

  // driver side of the scoreboard: keep items sorted by cycle
  task automatic expect_at(input int c, input bit v, input string r);
    exp_t e;
    int   pos;
    e.c = c; e.v = v; e.r = r;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].c > c) begin pos = i; break; end
    end
    sb.insert(pos, e);
  endtask

  task automatic go(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: compare at the falling edge after the posedge counted in cyc
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].c <= cyc) begin
      if (sb[0].c < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s: item for cycle %0d missed, actual cycle %0d expected %0d",
                 sb[0].r, sb[0].c, cyc, sb[0].c);
      end else begin
        check(dout, sb[0].v, sb[0].r, cyc);
      end
      void'(sb.pop_front());
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run incomplete, actual cycle %0d expected below 200000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int b;
    done = 1'b0; n_chk = 0; n_fail = 0;
    rst_n = 1'b0; trig = 1'b0; abort = 1'b0;
    mode = 2'b00; dly = 8'd0; tsel = 2'b00;
    repeat (3) @(negedge clk);
    check(dout, 1'b1, "R1 in reset", cyc);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dout, 1'b1, "R1 after release", cyc);

    // R3 pulse, N=8: retrigger and fall during the delay are ignored
    mode = 2'b00; dly = 8'd8; tsel = 2'b00;
    @(negedge clk); b = cyc;
    trig = 1'b1;
    expect_at(b + 2,  1'b1, "R9 latency before edge");
    expect_at(b + 3,  1'b0, "R3 immediate low");
    expect_at(b + 10, 1'b0, "R3 still low before expiry");
    expect_at(b + 11, 1'b1, "R3 high after 8 ticks");
    expect_at(b + 16, 1'b1, "R3 retrigger ignored");
    go(b + 4);  trig = 1'b0;
    go(b + 6);  trig = 1'b1;
    go(b + 20); trig = 1'b0;
    go(b + 30);

    // R4 delayed pull-in, N=4
    mode = 2'b01; dly = 8'd4;
    @(negedge clk); b = cyc;
    trig = 1'b1;
    expect_at(b + 6,  1'b1, "R4 high until expiry");
    expect_at(b + 7,  1'b0, "R4 low after 4 ticks");
    go(b + 10); trig = 1'b0;
    expect_at(b + 12, 1'b0, "R4 low before fall lands");
    expect_at(b + 13, 1'b1, "R4 immediate release");
    go(b + 20); b = cyc;
    trig = 1'b1;
    go(b + 2);  trig = 1'b0;
    expect_at(b + 7, 1'b1, "R4 fall cancels pending");
    expect_at(b + 9, 1'b1, "R4 stays released");
    go(b + 15);

    // R5 delayed drop-out, N=3
    mode = 2'b10; dly = 8'd3;
    @(negedge clk); b = cyc;
    trig = 1'b1;
    expect_at(b + 3, 1'b0, "R5 immediate low");
    go(b + 5); trig = 1'b0;
    expect_at(b + 10, 1'b0, "R5 low until expiry");
    expect_at(b + 11, 1'b1, "R5 high after 3 ticks");
    go(b + 20); b = cyc;
    trig = 1'b1;
    expect_at(b + 3, 1'b0, "R5 second low");
    go(b + 5); trig = 1'b0;
    go(b + 7); trig = 1'b1;
    expect_at(b + 12, 1'b0, "R5 rise cancels release");
    expect_at(b + 14, 1'b0, "R5 stays low");
    go(b + 20); trig = 1'b0;
    expect_at(b + 25, 1'b0, "R5 release pending");
    expect_at(b + 26, 1'b1, "R5 released after restart");
    go(b + 32);

    // R6 both delayed, N=2
    mode = 2'b11; dly = 8'd2;
    @(negedge clk); b = cyc;
    trig = 1'b1;
    expect_at(b + 3, 1'b1, "R6 no immediate change");
    expect_at(b + 4, 1'b1, "R6 high before expiry");
    expect_at(b + 5, 1'b0, "R6 low after 2 ticks");
    go(b + 10); trig = 1'b0;
    expect_at(b + 14, 1'b0, "R6 low before release");
    expect_at(b + 15, 1'b1, "R6 high after 2 ticks");
    go(b + 25); b = cyc;
    trig = 1'b1;
    go(b + 1); trig = 1'b0;
    expect_at(b + 5, 1'b1, "R6 fall replaces pull-in");
    expect_at(b + 7, 1'b1, "R6 stays high");
    go(b + 15);

    // R7 zero delay in three modes
    mode = 2'b01; dly = 8'd0;
    @(negedge clk); b = cyc;
    trig = 1'b1;
    expect_at(b + 2, 1'b1, "R7 pull-in before edge");
    expect_at(b + 3, 1'b0, "R7 pull-in zero delay");
    go(b + 6); trig = 1'b0;
    expect_at(b + 9, 1'b1, "R7 pull-in release");
    go(b + 14);
    mode = 2'b00;
    @(negedge clk); b = cyc;
    trig = 1'b1;
    expect_at(b + 3, 1'b1, "R7 pulse merges to high");
    expect_at(b + 4, 1'b1, "R7 pulse no glitch");
    go(b + 6); trig = 1'b0;
    go(b + 12);
    mode = 2'b10;
    @(negedge clk); b = cyc;
    trig = 1'b1;
    expect_at(b + 3, 1'b0, "R7 drop-out low");
    go(b + 6); trig = 1'b0;
    expect_at(b + 8, 1'b0, "R7 drop-out before fall");
    expect_at(b + 9, 1'b1, "R7 drop-out zero delay");
    go(b + 14);

    // R2 divided time bases
    mode = 2'b00; dly = 8'd3; tsel = 2'b01;
    @(negedge clk); b = cyc;
    trig = 1'b1;
    expect_at(b + 3,   1'b0, "R2 div50 start");
    expect_at(b + 152, 1'b0, "R2 div50 before 150 clocks");
    expect_at(b + 153, 1'b1, "R2 div50 after 150 clocks");
    go(b + 10); trig = 1'b0;
    go(b + 160);
    mode = 2'b01; dly = 8'd2; tsel = 2'b10;
    @(negedge clk); b = cyc;
    trig = 1'b1;
    expect_at(b + 122, 1'b1, "R2 div60 before 120 clocks");
    expect_at(b + 123, 1'b0, "R2 div60 after 120 clocks");
    go(b + 130); trig = 1'b0;
    expect_at(b + 133, 1'b1, "R4 release at div60");
    go(b + 140);
    mode = 2'b00; dly = 8'd1; tsel = 2'b11;
    @(negedge clk); b = cyc;
    trig = 1'b1;
    expect_at(b + 3,     1'b0, "R2 div32768 start");
    expect_at(b + 32770, 1'b0, "R2 div32768 before one tick");
    expect_at(b + 32771, 1'b1, "R2 div32768 after one tick");
    go(b + 20); trig = 1'b0;
    go(b + 32780);

    // R8 abort
    mode = 2'b00; dly = 8'd10; tsel = 2'b00;
    @(negedge clk); b = cyc;
    trig = 1'b1;
    expect_at(b + 3, 1'b0, "R3 low before abort");
    go(b + 5); abort = 1'b1;
    expect_at(b + 7,  1'b0, "R8 abort latency");
    expect_at(b + 8,  1'b1, "R8 abort forces high");
    go(b + 10); trig = 1'b0;
    go(b + 12); trig = 1'b1;
    expect_at(b + 20, 1'b1, "R8 edges ignored under abort");
    go(b + 22); abort = 1'b0;
    go(b + 26); trig = 1'b0;
    go(b + 30); trig = 1'b1;
    expect_at(b + 32, 1'b1, "R8 idle after release");
    expect_at(b + 33, 1'b0, "R8 new pulse after release");
    expect_at(b + 42, 1'b0, "R8 full length delay");
    expect_at(b + 43, 1'b1, "R8 delay ends after 10 ticks");
    go(b + 50); trig = 1'b0;
    go(b + 60);

    while (sb.size() > 0) begin
      n_chk++; n_fail++;
      $display("FAIL %s: item for cycle %0d never compared, actual cycle %0d expected %0d",
               sb[0].r, sb[0].c, cyc, sb[0].c);
      void'(sb.pop_front());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule